// File: doc/BRIEF.md
# Program Flow Control Unit

This unit sits beside the execute stage of a small 16-bit controller and owns the instruction pointer. It retires one instruction word per clock. It decodes only the branch-class words: plain and conditional jumps, loop-counter decrement-and-branch, subroutine calls, and conditional returns. Each of these words updates the instruction pointer, a 16-entry hardware return stack and two loop counters. Every other word moves the pointer forward by one.

The register map outside the unit resolves the source operand and hands it in as `src_i`. The status flags C, Z, E and S come in as separate pins. The interrupt controller tells the unit when an interrupt is accepted, so that the interrupt-in-service field is observable and the return-from-interrupt path can restore it. All state is held in registers, so every result is visible on the outputs just after the clock edge that samples the instruction.

Top module: `flow_ctrl_unit`

## Requirements
- R1: While reset is asserted and directly after it is released, ip_o, sp_o, lc0_o and lc1_o are 0, ips_o is 2'b11 and stk_err_o is 0. The return stack entries are all 0.
- R2: A word that is not a branch-class word sets ip_o to ip_o+1 and leaves sp_o, both loop counters and the stack unchanged. This covers bits 11:8 other than 1100/1101, the word 1000 1101 xxxx xxxx, and 1101 words with bits 14:12 other than 011, 100 or 101.
- R3: A jump word has bits 11:8 = 1100. With bits 14:12 = 000 it always branches. Bit 15 = 0 gives a target of ip + src_i and bit 15 = 1 gives a target of src_i, both modulo 2^16.
- R4: For a jump word, the field in bits 14:12 picks the condition: 010 C=1, 110 C=0, 001 Z=1, 101 Z=0, 011 E=1, 111 E=0, 100 S=1. When the condition is false, ip_o becomes ip_o+1.
- R5: An E-conditioned jump (bits 14:12 = 011 or 111) exists only with bit 15 = 0. With bit 15 = 1 the word is a non-branch word and behaves as in R2.
- R6: A call word is f011 1101 ssss ssss. It increments sp_o (modulo 16), stores ip+1 in the entry at the new sp_o, and branches to the R3 target.
- R7: A loop word is f10n 1101 ssss ssss. Bit 12 = n selects lc0_o or lc1_o. The selected counter is decremented modulo 2^16, and the unit branches to the R3 target only if the new value is nonzero; otherwise ip_o becomes ip_o+1.
- R8: A return word is 1ccc 1100 0000 1101, and its condition field uses the R4 codes. When the condition holds, ip_o takes the stack entry at sp_o and sp_o is then decremented. When the condition is false, ip_o becomes ip_o+1 and sp_o is unchanged. E codes (011, 111) on a return word act as R2.
- R9: A return-from-interrupt word is 1ccc 1100 1000 1101. When its condition holds, it behaves as R8 and also sets ips_o to 2'b11. When its condition is false, ips_o is unchanged.
- R10: The stack tracks an occupancy of 0 to 16. A call when the occupancy is 16, or a taken return when it is 0, sets stk_err_o. The flag stays at 1 until reset. The pointer still wraps modulo 16, and the occupancy saturates at its limit.
- R11: When irq_enter_i is 1, ips_o takes irq_lvl_i at the clock edge. If a taken return-from-interrupt arrives in the same cycle, the interrupt entry wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Instruction word retired this cycle |
| src_i | input | 16 | Resolved source operand |
| flag_c_i | input | 1 | Carry flag |
| flag_z_i | input | 1 | Zero flag |
| flag_e_i | input | 1 | Equal flag |
| flag_s_i | input | 1 | Sign flag |
| irq_enter_i | input | 1 | Interrupt accepted this cycle |
| irq_lvl_i | input | 2 | In-service value to load on interrupt entry |
| ip_o | output | 16 | Instruction pointer |
| sp_o | output | 4 | Return stack pointer |
| lc0_o | output | 16 | Loop counter 0 |
| lc1_o | output | 16 | Loop counter 1 |
| ips_o | output | 2 | Interrupt-in-service field |
| stk_err_o | output | 1 | Sticky stack overflow/underflow flag |

## Verification
Every output is a register, so each word's effect on ip_o, sp_o, the loop counters, ips_o and stk_err_o is due one clock edge after the word is presented. The driver applies a word on a falling edge and queues the state a reference model predicts for it. The monitor pops the queue one time unit after the next rising edge, so each comparison lines up with the single register stage. The reset state is sampled directly on the falling edge where reset is released, before any word is applied.

// File: rtl/flow_pkg.sv
package flow_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_JUMP,
    OP_CALL,
    OP_LOOP,
    OP_RET,
    OP_RETI
  } flow_op_e;

  typedef struct packed {
    flow_op_e   op;
    logic       abs_tgt;
    logic [2:0] cc;
    logic       lc_sel;
  } flow_dec_t;

  localparam logic [3:0] GRP_JMP  = 4'b1100;
  localparam logic [3:0] GRP_SUB  = 4'b1101;
  localparam logic [7:0] LO_RET   = 8'h0D;
  localparam logic [7:0] LO_RETI  = 8'h8D;
  localparam logic [2:0] CC_CALL  = 3'b011;
  localparam logic [1:0] CC_LOOP  = 2'b10;

  function automatic logic cc_is_e(input logic [2:0] cc);
    return cc[1:0] == 2'b11;
  endfunction

endpackage

// File: rtl/flow_decode.sv
module flow_decode
  import flow_pkg::*;
(
  input  logic [15:0] instr_i,
  output flow_dec_t   dec_o
);

  logic [3:0] grp;
  logic [7:0] lo;
  logic       f;
  logic [2:0] cc;

  assign grp = instr_i[11:8];
  assign lo  = instr_i[7:0];
  assign f   = instr_i[15];
  assign cc  = instr_i[14:12];

  always_comb begin
    dec_o         = '0;
    dec_o.op      = OP_NONE;
    dec_o.abs_tgt = f;
    dec_o.cc      = cc;
    dec_o.lc_sel  = instr_i[12];
    if (grp == GRP_JMP) begin
      if (f && (lo == LO_RET || lo == LO_RETI)) begin
        // no E-conditioned return exists
        if (!cc_is_e(cc)) dec_o.op = (lo == LO_RETI) ? OP_RETI : OP_RET;
      end else if (!(f && cc_is_e(cc))) begin
        dec_o.op = OP_JUMP;
      end
    end else if (grp == GRP_SUB) begin
      if (cc == CC_CALL)           dec_o.op = OP_CALL;
      else if (cc[2:1] == CC_LOOP) dec_o.op = OP_LOOP;
    end
  end

endmodule

// File: rtl/flow_cond.sv
module flow_cond (
  input  logic [2:0] cc_i,
  input  logic       c_i,
  input  logic       z_i,
  input  logic       e_i,
  input  logic       s_i,
  output logic       hit_o
);

  always_comb begin
    unique case (cc_i)
      3'b000:  hit_o = 1'b1;
      3'b010:  hit_o = c_i;
      3'b110:  hit_o = !c_i;
      3'b001:  hit_o = z_i;
      3'b101:  hit_o = !z_i;
      3'b011:  hit_o = e_i;
      3'b111:  hit_o = !e_i;
      default: hit_o = s_i;   // 100
    endcase
  end

endmodule

// File: rtl/flow_rstack.sv
module flow_rstack #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [PW-1:0] sp_o,
  output logic [DW-1:0] top_o,
  output logic          err_o
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] sp_q;
  logic [CW-1:0] cnt_q;
  logic          err_q;
  logic [PW-1:0] sp_inc;

  assign sp_inc = sp_q + 1'b1;
  assign sp_o   = sp_q;
  assign top_o  = mem_q[sp_q];
  assign err_o  = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q  <= '0;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (push_i) begin
      sp_q <= sp_inc;
      if (cnt_q == CW'(DEPTH)) err_q <= 1'b1;
      else                     cnt_q <= cnt_q + 1'b1;
    end else if (pop_i) begin
      sp_q <= sp_q - 1'b1;
      if (cnt_q == '0) err_q <= 1'b1;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            mem_q[g] <= '0;
      else if (push_i && sp_inc == PW'(g))    mem_q[g] <= wdata_i;
    end
  end

  AST_PUSH_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> sp_q == PW'($past(sp_q) + 1'b1)); // R6
  AST_POP_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> sp_q == PW'($past(sp_q) - 1'b1)); // R8
  AST_PUSH_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> top_o == $past(wdata_i)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q); // R10
  AST_ONE_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i)); // R6

endmodule

// File: rtl/flow_ctrl_unit.sv
module flow_ctrl_unit
  import flow_pkg::*;
#(
  parameter int AW    = 16,
  parameter int LCW   = 16,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [15:0]    instr_i,
  input  logic [AW-1:0]  src_i,
  input  logic           flag_c_i,
  input  logic           flag_z_i,
  input  logic           flag_e_i,
  input  logic           flag_s_i,
  input  logic           irq_enter_i,
  input  logic [1:0]     irq_lvl_i,
  output logic [AW-1:0]  ip_o,
  output logic [PW-1:0]  sp_o,
  output logic [LCW-1:0] lc0_o,
  output logic [LCW-1:0] lc1_o,
  output logic [1:0]     ips_o,
  output logic           stk_err_o
);

  localparam int NLC = 2;  // counter select is one instruction bit

  flow_dec_t     dec;
  logic          hit;
  logic [AW-1:0] ip_q, ip_d, ip_inc, target, stk_top;
  logic [LCW-1:0] lc_q [NLC];
  logic [LCW-1:0] lc_nxt;
  logic          push, pop, reti_go;
  logic [1:0]    ips_q;

  flow_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  flow_cond u_cond (
    .cc_i  (dec.cc),
    .c_i   (flag_c_i),
    .z_i   (flag_z_i),
    .e_i   (flag_e_i),
    .s_i   (flag_s_i),
    .hit_o (hit)
  );

  assign push    = dec.op == OP_CALL;
  assign pop     = (dec.op == OP_RET || dec.op == OP_RETI) && hit;
  assign reti_go = dec.op == OP_RETI && hit;

  flow_rstack #(.DW(AW), .DEPTH(DEPTH)) u_stk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .wdata_i (ip_inc),
    .sp_o    (sp_o),
    .top_o   (stk_top),
    .err_o   (stk_err_o)
  );

  assign ip_inc = ip_q + 1'b1;
  assign target = dec.abs_tgt ? src_i : ip_q + src_i;
  assign lc_nxt = lc_q[dec.lc_sel] - 1'b1;

  always_comb begin
    ip_d = ip_inc;
    unique case (dec.op)
      OP_JUMP:         if (hit) ip_d = target;
      OP_CALL:         ip_d = target;
      OP_LOOP:         if (lc_nxt != '0) ip_d = target;
      OP_RET, OP_RETI: if (hit) ip_d = stk_top;
      default:         ip_d = ip_inc;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ip_q <= '0;
    else         ip_q <= ip_d;
  end

  for (genvar g = 0; g < NLC; g++) begin : g_lc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        lc_q[g] <= '0;
      else if (dec.op == OP_LOOP && dec.lc_sel == 1'(g))  lc_q[g] <= lc_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ips_q <= 2'b11;
    else if (irq_enter_i) ips_q <= irq_lvl_i;
    else if (reti_go)     ips_q <= 2'b11;
  end

  assign ip_o  = ip_q;
  assign lc0_o = lc_q[0];
  assign lc1_o = lc_q[1];
  assign ips_o = ips_q;

  AST_NOBR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec.op == OP_NONE |=> ip_q == AW'($past(ip_q) + 1'b1)); // R2
  AST_NOBR_SP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec.op == OP_NONE |=> $stable(sp_o)); // R2
  AST_FALSE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.op == OP_JUMP && !hit) |=> ip_q == AW'($past(ip_q) + 1'b1)); // R4
  AST_LOOP0_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.op == OP_LOOP && !dec.lc_sel) |=> lc_q[0] == LCW'($past(lc_q[0]) - 1'b1)); // R7
  AST_LOOP0_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.op != OP_LOOP) |=> $stable(lc_q[0]) && $stable(lc_q[1])); // R7
  AST_RETI_IPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_go && !irq_enter_i) |=> ips_q == 2'b11); // R9
  AST_IRQ_IPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_enter_i |=> ips_q == $past(irq_lvl_i)); // R11

endmodule

// File: tb/tb_flow_ctrl_unit.sv
module tb_flow_ctrl_unit;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] ip;
    logic [3:0]  sp;
    logic [15:0] lc0;
    logic [15:0] lc1;
    logic [1:0]  ips;
    logic        err;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] instr = 16'hDA3A;
  logic [15:0] src = '0;
  logic        fc = 0, fz = 0, fe = 0, fs = 0;
  logic        irq = 0;
  logic [1:0]  lvl = '0;
  logic [15:0] ip_o, lc0_o, lc1_o;
  logic [3:0]  sp_o;
  logic [1:0]  ips_o;
  logic        err_o;

  int checks = 0;
  int fails  = 0;

  exp_t  eq[$];
  string tq[$];

  // reference model state
  logic [15:0] m_ip;
  logic [3:0]  m_sp;
  logic [15:0] m_lc [2];
  logic [1:0]  m_ips;
  logic        m_err;
  int          m_cnt;
  logic [15:0] m_stk [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  flow_ctrl_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .instr_i(instr), .src_i(src),
    .flag_c_i(fc), .flag_z_i(fz), .flag_e_i(fe), .flag_s_i(fs),
    .irq_enter_i(irq), .irq_lvl_i(lvl),
    .ip_o(ip_o), .sp_o(sp_o), .lc0_o(lc0_o), .lc1_o(lc1_o),
    .ips_o(ips_o), .stk_err_o(err_o)
  );

  function automatic exp_t model_now();
    exp_t e;
    e.ip = m_ip; e.sp = m_sp; e.lc0 = m_lc[0]; e.lc1 = m_lc[1];
    e.ips = m_ips; e.err = m_err;
    return e;
  endfunction

  task automatic compare(input exp_t e, input string tag);
    exp_t a;
    a.ip = ip_o; a.sp = sp_o; a.lc0 = lc0_o; a.lc1 = lc1_o;
    a.ips = ips_o; a.err = err_o;
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s ip=%h/%h sp=%h/%h lc0=%h/%h lc1=%h/%h ips=%b/%b err=%b/%b (actual/expected)",
               tag, a.ip, e.ip, a.sp, e.sp, a.lc0, e.lc0, a.lc1, e.lc1, a.ips, e.ips, a.err, e.err);
    end
  endtask

  function automatic logic cond_ok(input logic [2:0] cc);
    case (cc)
      3'b000: return 1'b1;
      3'b010: return fc;
      3'b110: return !fc;
      3'b001: return fz;
      3'b101: return !fz;
      3'b011: return fe;
      3'b111: return !fe;
      default: return fs;
    endcase
  endfunction

  // driver: apply word, predict, queue expectation
  task automatic exec(input logic [15:0] w, input logic [15:0] s, input logic [3:0] fl,
                      input logic ir, input logic [1:0] lv, input string tag);
    logic [15:0] nip, tgt;
    logic [2:0]  cc;
    logic        eflag, reti;
    instr = w; src = s; {fc, fz, fe, fs} = fl; irq = ir; lvl = lv;
    cc = w[14:12];
    eflag = (cc[1:0] == 2'b11);
    reti = 1'b0;
    nip = m_ip + 16'd1;
    tgt = w[15] ? s : m_ip + s;
    if (w[11:8] == 4'hC) begin
      if (w[15] && (w[7:0] == 8'h0D || w[7:0] == 8'h8D)) begin
        if (!eflag && cond_ok(cc)) begin
          if (m_cnt == 0) m_err = 1'b1; else m_cnt--;
          nip = m_stk[m_sp];
          m_sp = m_sp - 4'd1;
          reti = (w[7:0] == 8'h8D);
        end
      end else if (!(w[15] && eflag)) begin
        if (cond_ok(cc)) nip = tgt;
      end
    end else if (w[11:8] == 4'hD) begin
      if (cc == 3'b011) begin
        if (m_cnt == 16) m_err = 1'b1; else m_cnt++;
        m_sp = m_sp + 4'd1;
        m_stk[m_sp] = m_ip + 16'd1;
        nip = tgt;
      end else if (cc[2:1] == 2'b10) begin
        m_lc[cc[0]] = m_lc[cc[0]] - 16'd1;
        if (m_lc[cc[0]] != 16'd0) nip = tgt;
      end
    end
    if (ir)        m_ips = lv;
    else if (reti) m_ips = 2'b11;
    m_ip = nip;
    eq.push_back(model_now());
    tq.push_back(tag);
    @(negedge clk);
  endtask

  task automatic run(input logic [15:0] w, input logic [15:0] s, input logic [3:0] fl,
                     input string tag);
    exec(w, s, fl, 1'b0, 2'b00, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    instr = 16'hDA3A; irq = 0;
    m_ip = '0; m_sp = '0; m_lc[0] = '0; m_lc[1] = '0; m_ips = 2'b11; m_err = 0; m_cnt = 0;
    for (int i = 0; i < 16; i++) m_stk[i] = '0;
    repeat (2) @(negedge clk);
    compare(model_now(), "R1 in reset");
    rst_ni = 1'b1;
    #1;
    compare(model_now(), "R1 after release");
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (eq.size() > 0) compare(eq.pop_front(), tq.pop_front());
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R2: non-branch words
    run(16'hDA3A, 16'h0000, 4'h0, "R2 nop");
    run(16'h0D05, 16'h0030, 4'hF, "R2 push word");
    run(16'h1D00, 16'h0030, 4'hF, "R2 1101 cc=001");
    run(16'hF2AA, 16'h0030, 4'hF, "R2 other group");
    // R3: unconditional
    run(16'h0C00, 16'h0100, 4'h0, "R3 relative");
    run(16'h8C00, 16'h1234, 4'h0, "R3 absolute");
    run(16'h0C00, 16'hFFF0, 4'h0, "R3 relative wrap");
    // R4/R5: every condition code against every flag pattern
    for (int cc = 0; cc < 8; cc++) begin
      for (int fl = 0; fl < 16; fl++) begin
        run({1'b0, 3'(cc), 4'hC, 8'h05}, 16'h0005, 4'(fl), (cc % 4 == 3) ? "R5 E jump" : "R4 rel cond");
        if (cc % 4 != 3)
          run({1'b1, 3'(cc), 4'hC, 8'h40}, 16'h0400 + 16'(fl), 4'(fl), "R4 abs cond");
      end
    end
    run(16'hBC40, 16'h0777, 4'b0010, "R5 abs E treated as non-branch");
    run(16'hFC40, 16'h0777, 4'b0000, "R5 abs NE treated as non-branch");
    // R6/R8: call and returns
    run(16'hBD00, 16'h2000, 4'h0, "R6 call abs");
    run(16'h3D00, 16'h0010, 4'h0, "R6 call rel");
    run(16'hAC0D, 16'h0000, 4'b0000, "R8 ret C false");
    run(16'hBC0D, 16'h0000, 4'b0010, "R8 E return word non-branch");
    run(16'hAC0D, 16'h0000, 4'b1000, "R8 ret C true");
    run(16'h8C0D, 16'h0000, 4'h0, "R8 ret always");
    // R9/R11: interrupt-in-service field
    exec(16'hDA3A, 16'h0, 4'h0, 1'b1, 2'b01, "R11 irq entry");
    run(16'hBD00, 16'h3000, 4'h0, "R6 call before reti");
    run(16'h8C8D, 16'h0000, 4'h0, "R9 reti taken");
    exec(16'hDA3A, 16'h0, 4'h0, 1'b1, 2'b10, "R11 irq entry 2");
    run(16'hBD00, 16'h3100, 4'h0, "R6 call before reti 2");
    run(16'hDC8D, 16'h0000, 4'b0100, "R9 reti NZ false keeps ips");
    exec(16'hDC8D, 16'h0000, 4'b0000, 1'b1, 2'b00, "R11 irq beats reti");
    // R10: overflow
    do_reset();
    for (int i = 0; i < 16; i++) run(16'hBD00, 16'h1000 + 16'(i), 4'h0, "R10 fill");
    run(16'hBD00, 16'h1100, 4'h0, "R10 overflow");
    run(16'hDA3A, 16'h0, 4'h0, "R10 sticky");
    run(16'h8C0D, 16'h0, 4'h0, "R10 sticky after pop");
    // R10: underflow
    do_reset();
    run(16'h8C0D, 16'h0, 4'h0, "R10 underflow");
    run(16'hDA3A, 16'h0, 4'h0, "R10 sticky underflow");
    // R7: loop counters
    do_reset();
    run(16'h5D00, 16'h0010, 4'h0, "R7 loop lc1 rel");
    run(16'hCD00, 16'h0300, 4'h0, "R7 loop lc0 abs");
    for (int i = 0; i < 65535; i++) run(16'h4D00, 16'h0010, 4'h0, "R7 loop lc0 to zero");
    run(16'h4D00, 16'h0010, 4'h0, "R7 loop lc0 wraps");
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule